// File: doc/BRIEF.md
# Double-Precision Shift Unit

This block computes the two double-precision funnel shifts of the x86 integer unit: shift-left-double and shift-right-double. Each one shifts a destination operand and fills the vacated bit positions from a second source operand. Both directions work on 32-bit and 16-bit operands. Each clock the block takes the destination operand, the source operand, a count, a width select and a direction select. One cycle later it presents the shifted result and a flag that marks an out-of-range count.

In 16-bit mode the block does not produce arbitrary data for counts past the operand width. It returns the same consistent value that real silicon returns. The two 16-bit operands are joined into one 32-bit word, with the source in the upper half and the destination in the lower half. That word is rotated by the full masked count, and the low half is returned. As a result, counts of 16 to 31 behave as if the two operands had swapped roles. The flag tells a simulator or an analysis tool that the architectural result is officially undefined, while the data path still returns the value the hardware would give.

Top module: `dsh_unit`

## Requirements
- R1: Only the five low bits of `shCount` form the effective count c. The upper bits of `shCount` have no effect on either output.
- R2: With `narrowSel`=0 and `rightSel`=0 (32-bit left), for c in 1..31 `shResult` equals the low 32 bits of (opA << c) | (opB >> (32 - c)).
- R3: With `narrowSel`=0 and `rightSel`=1 (32-bit right), for c in 1..31 `shResult` equals the low 32 bits of (opA >> c) | (opB << (32 - c)).
- R4: With `narrowSel`=1 and `rightSel`=0, for c in 1..15 `shResult[15:0]` is the low half of the 32-bit word {opB[15:0], opA[15:0]} rotated left by c.
- R5: With `narrowSel`=1 and `rightSel`=1, for c in 1..15 `shResult[15:0]` is the low half of the word {opB[15:0], opA[15:0]} rotated right by c.
- R6: In 16-bit mode, counts of 16 to 31 still follow the rotate rule of R4 and R5. The result therefore equals the same-direction 16-bit shift with opA and opB swapped and a count of c & 15.
- R7: A count of c = 0 returns opA unchanged in 32-bit mode. In 16-bit mode it returns opA[15:0] zero-extended. In both cases `countUndef` stays low.
- R8: `countUndef` is 1 exactly when `narrowSel`=1 and c > 16. It is never raised in 32-bit mode.
- R9: In 16-bit mode `shResult[31:16]` is zero, and opA[31:16] and opB[31:16] have no effect on either output.
- R10: Both outputs appear one clock after the inputs are sampled. A synchronous active-low reset (`rstN`=0) clears `shResult` and `countUndef` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| opA | input | 32 | Destination operand (shifted operand) |
| opB | input | 32 | Source operand (fill bits) |
| shCount | input | 8 | Shift count; only bits [4:0] are used |
| narrowSel | input | 1 | 1 = 16-bit operands, 0 = 32-bit operands |
| rightSel | input | 1 | 1 = shift right double, 0 = shift left double |
| shResult | output | 32 | Shift result, registered |
| countUndef | output | 1 | Registered flag: 16-bit count above 16 |

## Verification
Every result, and the undefined flag that goes with it, is due exactly one rising edge after its operands, count and selects are applied. The bench applies a new stimulus on each falling edge and records the predicted pair in a queue. On the next falling edge, half a period after the register has loaded, it compares the outputs with the oldest queued entry. The full count range 0 to 31 is swept in all four width and direction combinations. Further cycles apply random upper count bits and random upper operand halves to show that the ignored inputs really are ignored.

// File: rtl/dsh_pkg.sv
package dsh_pkg;

  // Operand width of the wide mode; the narrow mode uses half of it.
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int WORD_W = 2 * DATA_W;
  localparam int CNT_W  = $clog2(DATA_W);
  // Shift amount into the funnel spans 0..DATA_W, hence one extra bit.
  localparam int AMT_W  = CNT_W + 1;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } dsh_dir_e;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic             narrowMode;
    dsh_dir_e         dir;
    logic [AMT_W-1:0] amt;
    logic             undef;
  } dsh_strobe_t;

endpackage

// File: rtl/dsh_ctrl.sv
module dsh_ctrl
  import dsh_pkg::*;
#(
  parameter int CNT_IN_W = 8
) (
  input  logic [CNT_IN_W-1:0] shCount,
  input  logic                narrowSel,
  input  logic                rightSel,
  output dsh_strobe_t         strobe
);

  logic [CNT_W-1:0] maskedCnt;
  logic [AMT_W-1:0] cntExt;
  logic             cntHiUnused;

  // The count is always reduced to its low bits, whatever the width.
  assign maskedCnt = shCount[CNT_W-1:0];
  assign cntExt    = {1'b0, maskedCnt};

  generate
    if (CNT_IN_W > CNT_W) begin : g_hiBits
      assign cntHiUnused = ^shCount[CNT_IN_W-1:CNT_W];
    end else begin : g_noHiBits
      assign cntHiUnused = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe.narrowMode = narrowSel;
    strobe.dir        = rightSel ? DIR_RIGHT : DIR_LEFT;
    // The datapath always shifts right. A left shift by c becomes a right
    // shift of the reordered word by DATA_W - c, which is DATA_W when c = 0.
    if (rightSel) begin
      strobe.amt = cntExt;
    end else begin
      strobe.amt = AMT_W'(DATA_W) - cntExt;
    end
    strobe.undef = narrowSel && (cntExt > AMT_W'(HALF_W));
  end

endmodule

// File: rtl/dsh_datapath.sv
module dsh_datapath
  import dsh_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  dsh_strobe_t       strobe,
  output logic [DATA_W-1:0] shResult,
  output logic              countUndef
);

  logic [DATA_W-1:0] narrowWord;
  logic [WORD_W-1:0] funnelIn;
  logic [WORD_W-1:0] stage [AMT_W+1];
  logic [DATA_W-1:0] nextResult;

  // In narrow mode the two halves form one word that is doubled, so a
  // right shift of the doubled word equals a rotate of the joined word.
  assign narrowWord = {opB[HALF_W-1:0], opA[HALF_W-1:0]};

  always_comb begin
    if (strobe.narrowMode) begin
      funnelIn = {narrowWord, narrowWord};
    end else if (strobe.dir == DIR_LEFT) begin
      funnelIn = {opA, opB};
    end else begin
      funnelIn = {opB, opA};
    end
  end

  assign stage[0] = funnelIn;

  // Logarithmic right shifter, one stage per bit of the shift amount.
  generate
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      assign stage[k+1] = strobe.amt[k] ? (stage[k] >> (1 << k)) : stage[k];
    end
  endgenerate

  always_comb begin
    if (strobe.narrowMode) begin
      nextResult = {{HALF_W{1'b0}}, stage[AMT_W][HALF_W-1:0]};
    end else begin
      nextResult = stage[AMT_W][DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shResult   <= '0;
      countUndef <= 1'b0;
    end else begin
      shResult   <= nextResult;
      countUndef <= strobe.undef;
    end
  end

  logic stageUnused;
  assign stageUnused = ^stage[AMT_W][WORD_W-1:DATA_W];

endmodule

// File: rtl/dsh_unit.sv
module dsh_unit
  import dsh_pkg::*;
#(
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [CNT_IN_W-1:0] shCount,
  input  logic                narrowSel,
  input  logic                rightSel,
  output logic [DATA_W-1:0]   shResult,
  output logic                countUndef
);

  dsh_strobe_t strobe;

  dsh_ctrl #(
    .CNT_IN_W(CNT_IN_W)
  ) u_ctrl (
    .shCount  (shCount),
    .narrowSel(narrowSel),
    .rightSel (rightSel),
    .strobe   (strobe)
  );

  dsh_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .strobe    (strobe),
    .shResult  (shResult),
    .countUndef(countUndef)
  );

endmodule

// File: rtl/dsh_unit_chk.sv
module dsh_unit_chk
  import dsh_pkg::*;
#(
  parameter int CNT_IN_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [DATA_W-1:0]   opA,
  input logic [DATA_W-1:0]   opB,
  input logic [CNT_IN_W-1:0] shCount,
  input logic                narrowSel,
  input logic                rightSel,
  input logic [DATA_W-1:0]   shResult,
  input logic                countUndef
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (shResult == '0) && !countUndef); // R10

  AST_WIDE_NEVER_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    !narrowSel |=> !countUndef); // R8

  AST_NARROW_UNDEF_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (narrowSel && (shCount[CNT_W-1:0] > CNT_W'(HALF_W))) |=> countUndef); // R8

  AST_NARROW_UNDEF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (narrowSel && (shCount[CNT_W-1:0] <= CNT_W'(HALF_W))) |=> !countUndef); // R8

  AST_WIDE_ZERO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!narrowSel && (shCount[CNT_W-1:0] == '0)) |=> (shResult == $past(opA))); // R7

  AST_NARROW_ZERO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (narrowSel && (shCount[CNT_W-1:0] == '0))
      |=> (shResult[HALF_W-1:0] == $past(opA[HALF_W-1:0]))); // R7

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    narrowSel |=> (shResult[DATA_W-1:HALF_W] == '0)); // R9

  logic unusedChk;
  assign unusedChk = ^{opB, rightSel};

endmodule

bind dsh_unit dsh_unit_chk #(.CNT_IN_W(CNT_IN_W)) u_chk (.*);

// File: tb/dsh_unit_tb.sv
module dsh_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [7:0]  shCount = '0;
  logic        narrowSel = 1'b0;
  logic        rightSel = 1'b0;
  logic [31:0] shResult;
  logic        countUndef;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] qRes[$];
  bit          qUnd[$];
  string       qTag[$];

  always #10 clk = ~clk;

  dsh_unit u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .shCount(shCount),
    .narrowSel(narrowSel), .rightSel(rightSel),
    .shResult(shResult), .countUndef(countUndef)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] want);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s got=%h want=%h", tag, got, want);
    end
  endtask

  // Behavioural model: plain shifts for 32 bits, bit-by-bit rotation for 16.
  function automatic logic [31:0] refResult(logic [31:0] a, logic [31:0] b,
                                            logic [7:0] cnt, bit nar, bit rt);
    int c = int'(cnt) % 32;
    logic [63:0] acc;
    logic [31:0] x;
    if (!nar) begin
      if (!rt) acc = ({32'b0, a} << c) | ({32'b0, b} >> (32 - c));
      else     acc = ({32'b0, a} >> c) | ({32'b0, b} << (32 - c));
      return acc[31:0];
    end
    x = {b[15:0], a[15:0]};
    for (int i = 0; i < c; i++) begin
      if (!rt) x = {x[30:0], x[31]};
      else     x = {x[0], x[31:1]};
    end
    return {16'b0, x[15:0]};
  endfunction

  // Called on a falling edge: check the result due now, then apply the next.
  task automatic stepCompare();
    if (qRes.size() > 0) begin
      logic [31:0] wantRes = qRes.pop_front();
      bit          wantUnd = qUnd.pop_front();
      string       tag     = qTag.pop_front();
      chk(tag, shResult, wantRes);
      chk("R8 undef flag", {31'b0, countUndef}, {31'b0, wantUnd});
      if (narrowSel === 1'b1 || wantRes[31:16] == 16'b0) begin
        if (tag.substr(0, 1) == "R4" || tag.substr(0, 1) == "R5" || tag.substr(0, 1) == "R6")
          chk("R9 upper half zero", {16'b0, shResult[31:16]}, 32'b0);
      end
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [7:0] cnt,
                       bit nar, bit rt);
    int c = int'(cnt) % 32;
    string tag;
    @(negedge clk);
    stepCompare();
    opA = a; opB = b; shCount = cnt; narrowSel = nar; rightSel = rt;
    if (cnt[7:5] != 3'b0)        tag = "R1 count mask";
    else if (c == 0)             tag = "R7 zero count";
    else if (nar && c >= 16)     tag = "R6 narrow swapped range";
    else if (nar && !rt)         tag = "R4 narrow left";
    else if (nar && rt)          tag = "R5 narrow right";
    else if (!rt)                tag = "R2 wide left";
    else                         tag = "R3 wide right";
    qRes.push_back(refResult(a, b, cnt, nar, rt));
    qUnd.push_back(nar && (c > 16));
    qTag.push_back(tag);
  endtask

  initial begin
    // R10: outputs held at zero during reset
    repeat (3) @(negedge clk);
    chk("R10 reset result", shResult, 32'b0);
    chk("R10 reset flag", {31'b0, countUndef}, 32'b0);
    rstN = 1'b1;

    // Full sweep of count, width and direction
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 32; c++) begin
        apply($urandom(), $urandom(), 8'(c), m[1], m[0]);
      end
    end

    // R6: fixed pattern, count 20 narrow left equals swapped operands by 4
    apply(32'h0000_1234, 32'h0000_abcd, 8'd20, 1'b1, 1'b0);
    apply(32'h0000_abcd, 32'h0000_1234, 8'd4, 1'b1, 1'b0);
    // R1 and R9: upper count bits and upper operand halves are random
    for (int i = 0; i < 64; i++) begin
      apply($urandom(), $urandom(), 8'($urandom()), 1'($urandom()), 1'($urandom()));
    end
    // R9: same low halves, different upper halves must agree
    apply(32'hffff_8001, 32'h5555_7ffe, 8'd9, 1'b1, 1'b1);
    apply(32'h0000_8001, 32'h0000_7ffe, 8'd9, 1'b1, 1'b1);
    // R3 boundary: count 31 wide right
    apply(32'h8000_0000, 32'h0000_0001, 8'd31, 1'b0, 1'b1);

    @(negedge clk);
    stepCompare();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog got=hung want=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule